// File: doc/BRIEF.md
# I2C Master Byte Transfer Sequencer

This block runs one I2C master transfer at byte granularity. Software-facing writes configure a control byte, a transfer-size count and a data FIFO. A write to the target address starts the transfer. The block then issues byte-level commands to a separate bus engine: START with address, write byte, read byte and STOP. The engine handles the wire timing and acknowledges each command with a done pulse. The engine reports a target NACK and delivers any received byte on that same done pulse.

One 16-entry FIFO is shared by both directions. In transmit mode the host fills it and the sequencer drains it onto the bus. In receive mode the engine fills it and the host drains it. A hold control keeps the bus claimed after the programmed bytes instead of issuing STOP. With hold set, a new address write produces a repeated START, and clearing hold releases the bus with STOP. In receive mode the remaining-byte count alone decides which read is answered with NACK, whatever the hold setting. Raw one-cycle event pulses report completion, target NACK, receive fill threshold, transmit overflow, receive overflow and receive underflow.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset the control readback is 0, the bus is inactive, no engine command is requested, receive data is not valid, the size readback is 0 and no event fires.
- R2: The control byte carries these bits: bit0 direction (1 = receive), bit1 master enable, bit2 seven-bit addressing, bit3 ACK enable, bit4 hold, bit6 clear-FIFO. An address write with master enable set requests a START command, op code 0, on the engine port; the other op codes are 1 for write, 2 for read and 3 for stop. The START carries the address masked to bits [6:0] in seven-bit mode or all 10 bits otherwise, and the direction bit as the read/write flag. An address write with master enable clear starts nothing.
- R3: In transmit mode, FIFO bytes are sent as write commands in the order they were written, and the size readback shows the FIFO fill count.
- R4: In transmit mode with hold clear, once the FIFO is empty a STOP command follows, and the completion event fires once after the STOP is done.
- R5: In transmit mode with hold set, an empty FIFO raises the completion event once and keeps the bus active without STOP. Refilling the FIFO resumes the write commands. Clearing hold issues STOP.
- R6: In receive mode each read command decrements the size count. A read carries the final-byte NACK flag exactly when the count is 1, whether or not hold is set. The count ends at 0.
- R7: In receive mode with hold set, after the last byte the completion event fires and the bus stays active without STOP. A new address write then issues a repeated START, and clearing hold issues STOP.
- R8: A target NACK raises the NACK event and leads to STOP and idle, with no completion event.
- R9: Received bytes are read out in arrival order. The data event fires once when the receive fill reaches 14 (depth minus 2).
- R10: A host write to a full transmit FIFO raises the transmit-overflow event and stores nothing. A byte received into a full FIFO raises the receive-overflow event and is dropped. A host read of an empty receive FIFO raises the receive-underflow event.
- R11: A control write with bit6 set empties the FIFO at once. Bit6 then reads back 1 for one cycle and 0 after that.
- R12: The receive-valid status is high exactly when receive mode holds data in the FIFO. The bus-active status is high from the START request until the STOP is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write value |
| ctrl_o | output | 8 | Control byte readback |
| addr_we_i | input | 1 | Address write strobe, starts a transfer |
| addr_wdata_i | input | 10 | Target address |
| size_we_i | input | 1 | Transfer-size write strobe |
| size_wdata_i | input | 8 | Bytes to receive |
| size_o | output | 8 | Remaining count (receive) or FIFO fill (transmit) |
| data_we_i | input | 1 | Transmit FIFO write strobe |
| data_wdata_i | input | 8 | Transmit byte |
| data_re_i | input | 1 | Receive FIFO read strobe |
| data_rdata_o | output | 8 | Receive FIFO head, 0 when empty |
| rx_valid_o | output | 1 | Receive data available |
| bus_active_o | output | 1 | Transfer in progress or bus held |
| eng_req_o | output | 1 | Command request to bus engine |
| eng_op_o | output | 2 | Command code: 0 start, 1 write, 2 read, 3 stop |
| eng_addr_o | output | 10 | Masked target address |
| eng_ten_o | output | 1 | Ten-bit address mode |
| eng_rw_o | output | 1 | Read/write flag for address phase |
| eng_wdata_o | output | 8 | Byte to transmit |
| eng_last_o | output | 1 | NACK this read byte |
| eng_done_i | input | 1 | Engine command finished |
| eng_nack_i | input | 1 | Target NACKed, valid with done |
| eng_rdata_i | input | 8 | Received byte, valid with done |
| ev_data_o | output | 1 | Receive fill reached threshold |
| ev_comp_o | output | 1 | Transfer complete or FIFO needs refill |
| ev_nack_o | output | 1 | Target NACK |
| ev_txovf_o | output | 1 | Transmit overflow |
| ev_rxovf_o | output | 1 | Receive overflow |
| ev_rxunf_o | output | 1 | Receive underflow |

## Verification
In receive mode the host draining the FIFO and the engine delivering a byte can fall in the same cycle. The FIFO then pushes and pops together, and the fill count and the threshold logic must treat that as no change. The bench provokes this by popping whenever receive data is valid during a 20-byte read, with the engine answering at random latencies. It judges the run by the popped sequence matching the delivered bytes exactly, with neither overflow nor underflow events. A second coincidence is a final-byte read landing while hold is set. The bench judges it by a NACK flag on that read with no STOP after it.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_TX, ST_TXWAIT, ST_RX, ST_HELD, ST_STOP
  } seq_state_e;

  localparam int CB_DIR    = 0;
  localparam int CB_MASTER = 1;
  localparam int CB_NORM   = 2;
  localparam int CB_ACKEN  = 3;
  localparam int CB_HOLD   = 4;
  localparam int CB_CLR    = 6;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)) else $error("fifo count beyond depth"); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o) else $error("flush left data"); // R11
  AST_FULL_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && $stable(wptr_q)) else $error("push into full fifo"); // R10
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    dir_i,
  input  logic    hold_i,
  input  logic    fifo_empty_i,
  input  logic    size_zero_i,
  input  logic    size_one_i,
  input  logic    eng_done_i,
  input  logic    eng_nack_i,
  output logic    eng_req_o,
  output eng_op_e eng_op_o,
  output logic    eng_last_o,
  output logic    tx_pop_o,
  output logic    rx_push_o,
  output logic    size_dec_o,
  output logic    comp_o,
  output logic    nack_o,
  output logic    busy_o
);
  seq_state_e state_q, state_d;
  logic       nacked_q, nacked_d;

  always_comb begin
    state_d    = state_q;
    nacked_d   = nacked_q;
    eng_req_o  = 1'b0;
    eng_op_o   = OP_START;
    eng_last_o = 1'b0;
    tx_pop_o   = 1'b0;
    rx_push_o  = 1'b0;
    size_dec_o = 1'b0;
    comp_o     = 1'b0;
    nack_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_ADDR;
        nacked_d = 1'b0;
      end
      ST_ADDR: begin
        eng_req_o = 1'b1;
        eng_op_o  = OP_START;
        if (eng_done_i) begin
          if (eng_nack_i) begin
            nack_o   = 1'b1;
            nacked_d = 1'b1;
            state_d  = ST_STOP;
          end else begin
            state_d = dir_i ? ST_RX : ST_TX;
          end
        end
      end
      ST_TX: begin
        if (!fifo_empty_i) begin
          eng_req_o = 1'b1;
          eng_op_o  = OP_WRITE;
          if (eng_done_i) begin
            tx_pop_o = 1'b1;
            if (eng_nack_i) begin
              nack_o   = 1'b1;
              nacked_d = 1'b1;
              state_d  = ST_STOP;
            end
          end
        end else if (hold_i) begin
          comp_o  = 1'b1;  // refill request, clock stretched
          state_d = ST_TXWAIT;
        end else begin
          state_d = ST_STOP;
        end
      end
      ST_TXWAIT: begin
        if (start_i)            state_d = ST_ADDR;
        else if (!fifo_empty_i) state_d = ST_TX;
        else if (!hold_i)       state_d = ST_STOP;
      end
      ST_RX: begin
        if (!size_zero_i) begin
          eng_req_o  = 1'b1;
          eng_op_o   = OP_READ;
          eng_last_o = size_one_i;  // count alone picks the NACKed byte
          if (eng_done_i) begin
            rx_push_o  = 1'b1;
            size_dec_o = 1'b1;
          end
        end else if (hold_i) begin
          comp_o  = 1'b1;
          state_d = ST_HELD;
        end else begin
          state_d = ST_STOP;
        end
      end
      ST_HELD: begin
        if (start_i)      state_d = ST_ADDR;
        else if (!hold_i) state_d = ST_STOP;
      end
      ST_STOP: begin
        eng_req_o = 1'b1;
        eng_op_o  = OP_STOP;
        if (eng_done_i) begin
          comp_o   = ~nacked_q;
          nacked_d = 1'b0;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      nacked_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      nacked_q <= nacked_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  AST_DONE_ONLY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |-> eng_req_o) else $error("done without request"); // R2
  AST_NACK_TO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_o |=> (state_q == ST_STOP) && !comp_o) else $error("nack not followed by stop"); // R8
  AST_HELD_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD) && hold_i && !start_i |=> (state_q == ST_HELD)) else $error("held bus released"); // R7
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 8,
  parameter int SIZE_W     = 8,
  parameter int ADDR_W     = 10,
  parameter int NORM_W     = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_o,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              size_we_i,
  input  logic [SIZE_W-1:0] size_wdata_i,
  output logic [SIZE_W-1:0] size_o,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic              data_re_i,
  output logic [DATA_W-1:0] data_rdata_o,
  output logic              rx_valid_o,
  output logic              bus_active_o,
  output logic              eng_req_o,
  output logic [1:0]        eng_op_o,
  output logic [ADDR_W-1:0] eng_addr_o,
  output logic              eng_ten_o,
  output logic              eng_rw_o,
  output logic [DATA_W-1:0] eng_wdata_o,
  output logic              eng_last_o,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic              ev_data_o,
  output logic              ev_comp_o,
  output logic              ev_nack_o,
  output logic              ev_txovf_o,
  output logic              ev_rxovf_o,
  output logic              ev_rxunf_o
);
  localparam int CW       = $clog2(FIFO_DEPTH + 1);
  localparam int DATA_THR = FIFO_DEPTH - 2;

  logic [7:0]        ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic              dir, flush, start;
  logic              f_push, f_pop, f_full, f_empty;
  logic [DATA_W-1:0] f_din, f_dout;
  logic [CW-1:0]     f_cnt;
  logic              tx_pop, rx_push, size_dec, comp, nack;
  logic              txovf, rxovf, rxunf, thr_hit;
  eng_op_e           op;

  assign dir   = ctrl_q[CB_DIR];
  assign flush = ctrl_we_i & ctrl_wdata_i[CB_CLR];
  assign start = addr_we_i & ctrl_q[CB_MASTER];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
      size_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      else           ctrl_q[CB_CLR] <= 1'b0;  // self-clearing
      if (addr_we_i) addr_q <= addr_wdata_i;
      if (size_we_i)     size_q <= size_wdata_i;
      else if (size_dec) size_q <= size_q - 1'b1;
    end
  end

  assign f_push = dir ? rx_push : data_we_i;
  assign f_din  = dir ? eng_rdata_i : data_wdata_i;
  assign f_pop  = dir ? data_re_i : tx_pop;

  i2c_seq_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (f_push),
    .data_i  (f_din),
    .pop_i   (f_pop),
    .data_o  (f_dout),
    .count_o (f_cnt),
    .full_o  (f_full),
    .empty_o (f_empty)
  );

  i2c_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .dir_i        (dir),
    .hold_i       (ctrl_q[CB_HOLD]),
    .fifo_empty_i (f_empty),
    .size_zero_i  (size_q == '0),
    .size_one_i   (size_q == SIZE_W'(1)),
    .eng_done_i   (eng_done_i),
    .eng_nack_i   (eng_nack_i),
    .eng_req_o    (eng_req_o),
    .eng_op_o     (op),
    .eng_last_o   (eng_last_o),
    .tx_pop_o     (tx_pop),
    .rx_push_o    (rx_push),
    .size_dec_o   (size_dec),
    .comp_o       (comp),
    .nack_o       (nack),
    .busy_o       (bus_active_o)
  );

  assign txovf   = ~dir & data_we_i & f_full & ~tx_pop & ~flush;
  assign rxovf   = dir & rx_push & f_full & ~data_re_i & ~flush;
  assign rxunf   = dir & data_re_i & f_empty;
  // fill reaches threshold only on a push without a paired pop
  assign thr_hit = dir & rx_push & ~(data_re_i & ~f_empty) & ~flush &
                   (f_cnt == CW'(DATA_THR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {ev_data_o, ev_comp_o, ev_nack_o, ev_txovf_o, ev_rxovf_o, ev_rxunf_o} <= '0;
    end else begin
      ev_data_o  <= thr_hit;
      ev_comp_o  <= comp;
      ev_nack_o  <= nack;
      ev_txovf_o <= txovf;
      ev_rxovf_o <= rxovf;
      ev_rxunf_o <= rxunf;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign size_o       = dir ? size_q : SIZE_W'(f_cnt);
  assign data_rdata_o = (dir && !f_empty) ? f_dout : '0;
  assign rx_valid_o   = dir & ~f_empty;
  assign eng_op_o     = op;
  assign eng_wdata_o  = f_dout;
  assign eng_rw_o     = dir;
  assign eng_ten_o    = ~ctrl_q[CB_NORM];
  assign eng_addr_o   = ctrl_q[CB_NORM] ? {{(ADDR_W-NORM_W){1'b0}}, addr_q[NORM_W-1:0]} : addr_q;

  AST_CLR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CB_CLR] && !ctrl_we_i |=> !ctrl_q[CB_CLR]) else $error("clear bit stuck"); // R11
  AST_RX_COUNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i && eng_req_o && (op == OP_READ) |-> size_q != '0) else $error("read past count"); // R6
  AST_TX_NO_RX_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir |=> !ev_rxovf_o && !ev_data_o) else $error("rx event in tx mode"); // R10
endmodule

// File: tb/i2c_byte_seq_tb.sv
module i2c_byte_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 0, addr_we_i = 0, size_we_i = 0, data_we_i = 0, data_re_i = 0;
  logic [7:0] ctrl_wdata_i = 0, size_wdata_i = 0, data_wdata_i = 0;
  logic [9:0] addr_wdata_i = 0;
  logic [7:0] ctrl_o, size_o, data_rdata_o, eng_wdata_o;
  logic       rx_valid_o, bus_active_o, eng_req_o, eng_ten_o, eng_rw_o, eng_last_o;
  logic [1:0] eng_op_o;
  logic [9:0] eng_addr_o;
  logic       eng_done_i, eng_nack_i;
  logic [7:0] eng_rdata_i;
  logic       ev_data_o, ev_comp_o, ev_nack_o, ev_txovf_o, ev_rxovf_o, ev_rxunf_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  i2c_byte_seq u_dut (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .ctrl_o, .addr_we_i, .addr_wdata_i,
    .size_we_i, .size_wdata_i, .size_o, .data_we_i, .data_wdata_i, .data_re_i,
    .data_rdata_o, .rx_valid_o, .bus_active_o, .eng_req_o, .eng_op_o, .eng_addr_o,
    .eng_ten_o, .eng_rw_o, .eng_wdata_o, .eng_last_o, .eng_done_i, .eng_nack_i,
    .eng_rdata_i, .ev_data_o, .ev_comp_o, .ev_nack_o, .ev_txovf_o, .ev_rxovf_o, .ev_rxunf_o
  );

  int checks = 0, errors = 0;
  int comp_n = 0, nack_n = 0, data_n = 0, txovf_n = 0, rxovf_n = 0, rxunf_n = 0;
  int log_n = 0;
  logic [1:0] op_log [64];
  logic [7:0] dat_log [64];
  logic [9:0] adr_log [64];
  logic       last_log [64];
  logic       rw_log [64];
  bit         nack_addr = 0;

  function automatic logic [9:0] exp_addr(input logic [9:0] a, input bit norm);
    return norm ? {3'b000, a[6:0]} : a;
  endfunction

  function automatic bit exp_last(input int idx, input int n);
    return idx == n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bus engine model
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    eng_done_i = 0; eng_nack_i = 0; eng_rdata_i = 0;
    forever begin
      @(negedge clk_i);
      if (eng_done_i) begin
        eng_done_i = 0;
        eng_nack_i = 0;
      end else if (rst_ni && eng_req_o) begin
        if (wait_cnt == 0) begin
          eng_rdata_i = 8'($urandom);
          if (log_n < 64) begin
            op_log[log_n]   = eng_op_o;
            adr_log[log_n]  = eng_addr_o;
            rw_log[log_n]   = eng_rw_o;
            last_log[log_n] = eng_last_o;
            dat_log[log_n]  = (eng_op_o == 2'd2) ? eng_rdata_i : eng_wdata_o;
          end
          log_n++;
          eng_nack_i = (eng_op_o == 2'd0) && nack_addr;
          eng_done_i = 1;
          wait_cnt = $urandom % 3;
        end else wait_cnt--;
      end
    end
  end

  // event monitor
  initial forever begin
    @(negedge clk_i);
    if (ev_comp_o)  comp_n++;
    if (ev_nack_o)  nack_n++;
    if (ev_data_o)  data_n++;
    if (ev_txovf_o) txovf_n++;
    if (ev_rxovf_o) rxovf_n++;
    if (ev_rxunf_o) rxunf_n++;
  end

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we_i = 1; ctrl_wdata_i = v; @(negedge clk_i); ctrl_we_i = 0;
  endtask
  task automatic wr_addr(input logic [9:0] v);
    addr_we_i = 1; addr_wdata_i = v; @(negedge clk_i); addr_we_i = 0;
  endtask
  task automatic wr_size(input logic [7:0] v);
    size_we_i = 1; size_wdata_i = v; @(negedge clk_i); size_we_i = 0;
  endtask
  task automatic push(input logic [7:0] v);
    data_we_i = 1; data_wdata_i = v; @(negedge clk_i); data_we_i = 0;
  endtask
  task automatic pop(output logic [7:0] v);
    data_re_i = 1; v = data_rdata_o; @(negedge clk_i); data_re_i = 0;
  endtask
  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask
  task automatic wait_idle(input string req);
    int t;
    t = 0;
    while (bus_active_o && t < 1000) begin @(negedge clk_i); t++; end
    chk(!bus_active_o, req, bus_active_o, 0);
  endtask
  task automatic wait_comp(input int target, input string req);
    int t;
    t = 0;
    while (comp_n < target && t < 1000) begin @(negedge clk_i); t++; end
    chk(comp_n == target, req, comp_n, target);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [7:0] sent [16];
    int c0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(ctrl_o == 0, "R1 ctrl", ctrl_o, 0);
    chk(!bus_active_o && !eng_req_o, "R1 idle", bus_active_o, 0);
    chk(!rx_valid_o && size_o == 0, "R1 fifo", size_o, 0);
    chk(comp_n + nack_n + data_n + txovf_n + rxovf_n + rxunf_n == 0, "R1 events", comp_n, 0);

    // R2 address write without master enable
    wr_ctrl(8'h04);
    wr_addr(10'h055);
    idle_cyc(6);
    chk(!eng_req_o && !bus_active_o && log_n == 0, "R2 no master", log_n, 0);

    // R3 R4 transmit, random lengths, both addressing modes
    for (int it = 0; it < 3; it++) begin
      int n;
      bit norm;
      logic [9:0] a;
      norm = (it != 1);
      n = 1 + ($urandom % 16);
      a = 10'($urandom);
      wr_ctrl(8'h42 | (norm ? 8'h04 : 8'h00));
      for (int i = 0; i < n; i++) begin
        sent[i] = 8'($urandom);
        push(sent[i]);
      end
      chk(size_o == 8'(n), "R3 fill readback", size_o, n);
      log_n = 0;
      c0 = comp_n;
      wr_addr(a);
      wait_idle("R4 idle after stop");
      chk(op_log[0] == 2'd0 && adr_log[0] == exp_addr(a, norm), "R2 start addr",
          adr_log[0], exp_addr(a, norm));
      chk(rw_log[0] == 1'b0, "R2 rw flag", rw_log[0], 0);
      for (int i = 0; i < n; i++)
        chk(op_log[i+1] == 2'd1 && dat_log[i+1] == sent[i], "R3 byte order", dat_log[i+1], sent[i]);
      chk(log_n == n + 2 && op_log[n+1] == 2'd3, "R4 stop last", log_n, n + 2);
      chk(comp_n == c0 + 1, "R4 comp once", comp_n, c0 + 1);
    end

    // R5 transmit with hold: stretch on empty, refill, release
    wr_ctrl(8'h56);
    push(8'hA1); push(8'hB2);
    log_n = 0; c0 = comp_n;
    wr_addr(10'h021);
    idle_cyc(40);
    chk(log_n == 3 && op_log[2] == 2'd1, "R5 no stop while held", log_n, 3);
    chk(comp_n == c0 + 1, "R5 refill comp", comp_n, c0 + 1);
    chk(bus_active_o, "R12 active while held", bus_active_o, 1);
    push(8'hC3);
    idle_cyc(30);
    chk(log_n == 4 && dat_log[3] == 8'hC3, "R5 resume", dat_log[3], 8'hC3);
    chk(comp_n == c0 + 2, "R5 second refill comp", comp_n, c0 + 2);
    wr_ctrl(8'h06);
    wait_idle("R5 release");
    chk(log_n == 5 && op_log[4] == 2'd3, "R5 stop on release", op_log[4], 3);
    chk(comp_n == c0 + 3, "R5 final comp", comp_n, c0 + 3);

    // R6 R9 R12 receive, random short sizes
    for (int it = 0; it < 2; it++) begin
      int n;
      n = 1 + ($urandom % 13);
      wr_ctrl(8'h47);
      wr_size(8'(n));
      log_n = 0; c0 = comp_n;
      wr_addr(10'h3C5);
      wait_idle("R6 rx done");
      chk(rw_log[0] == 1'b1 && adr_log[0] == exp_addr(10'h3C5, 1), "R2 rx start", adr_log[0], 10'h045);
      for (int i = 1; i <= n; i++)
        chk(op_log[i] == 2'd2 && last_log[i] == exp_last(i, n), "R6 last flag", last_log[i], exp_last(i, n));
      chk(op_log[n+1] == 2'd3 && comp_n == c0 + 1, "R6 stop comp", comp_n, c0 + 1);
      chk(size_o == 0, "R6 count zero", size_o, 0);
      chk(rx_valid_o, "R12 rx valid", rx_valid_o, 1);
      for (int i = 1; i <= n; i++) begin
        pop(b);
        chk(b == dat_log[i], "R9 rx order", b, dat_log[i]);
      end
      chk(!rx_valid_o, "R12 rx drained", rx_valid_o, 0);
    end
    c0 = rxunf_n;
    pop(b);
    idle_cyc(1);
    chk(rxunf_n == c0 + 1 && b == 0, "R10 underflow", rxunf_n, c0 + 1);

    // R9 R10 threshold and receive overflow
    wr_ctrl(8'h47);
    wr_size(8'd18);
    log_n = 0; c0 = data_n;
    begin
      int ov0;
      ov0 = rxovf_n;
      wr_addr(10'h011);
      wait_idle("R10 rx long done");
      chk(data_n == c0 + 1, "R9 threshold once", data_n, c0 + 1);
      chk(rxovf_n == ov0 + 2, "R10 rx overflow", rxovf_n, ov0 + 2);
    end
    for (int i = 1; i <= 16; i++) begin
      pop(b);
      chk(b == dat_log[i], "R10 kept bytes", b, dat_log[i]);
    end
    chk(!rx_valid_o, "R10 dropped extra", rx_valid_o, 0);

    // R9 concurrent host pop and engine push
    wr_ctrl(8'h47);
    wr_size(8'd20);
    log_n = 0;
    begin
      int got, t, ov0, un0;
      got = 0; t = 0; ov0 = rxovf_n; un0 = rxunf_n;
      wr_addr(10'h012);
      while ((bus_active_o || rx_valid_o) && t < 2000) begin
        if (rx_valid_o) begin
          pop(b);
          got++;
          chk(b == dat_log[got], "R9 concurrent order", b, dat_log[got]);
        end else @(negedge clk_i);
        t++;
      end
      chk(got == 20, "R9 concurrent count", got, 20);
      chk(rxovf_n == ov0 && rxunf_n == un0, "R10 no spurious", rxovf_n - ov0, 0);
    end

    // R7 receive with hold, repeated start, release
    wr_ctrl(8'h57);
    wr_size(8'd3);
    log_n = 0; c0 = comp_n;
    wr_addr(10'h050);
    wait_comp(c0 + 1, "R7 held comp");
    idle_cyc(5);
    chk(bus_active_o && log_n == 4, "R7 no stop", log_n, 4);
    chk(last_log[3] == 1'b1 && last_log[2] == 1'b0, "R6 last with hold", last_log[3], 1);
    for (int i = 0; i < 3; i++) pop(b);
    wr_size(8'd2);
    wr_addr(10'h051);
    wait_comp(c0 + 2, "R7 second held comp");
    idle_cyc(5);
    chk(op_log[4] == 2'd0 && adr_log[4] == 10'h051, "R7 repeated start", op_log[4], 0);
    chk(log_n == 7 && last_log[6] == 1'b1, "R7 second read", log_n, 7);
    wr_ctrl(8'h07);
    wait_idle("R7 release");
    chk(op_log[7] == 2'd3 && log_n == 8, "R7 stop", op_log[7], 3);

    // R8 address NACK
    wr_ctrl(8'h46);
    push(8'h11); push(8'h22); push(8'h33);
    nack_addr = 1;
    log_n = 0; c0 = comp_n;
    begin
      int nk0;
      nk0 = nack_n;
      wr_addr(10'h07F);
      wait_idle("R8 idle");
      idle_cyc(2);
      chk(nack_n == nk0 + 1, "R8 nack event", nack_n, nk0 + 1);
    end
    nack_addr = 0;
    chk(comp_n == c0, "R8 no comp", comp_n, c0);
    chk(log_n == 2 && op_log[1] == 2'd3, "R8 stop", log_n, 2);
    chk(size_o == 3, "R3 fifo kept", size_o, 3);

    // R11 clear FIFO
    wr_ctrl(8'h46);
    chk(size_o == 0 && ctrl_o[6], "R11 flushed, bit set", size_o, 0);
    idle_cyc(1);
    chk(!ctrl_o[6] && ctrl_o == 8'h06, "R11 bit cleared", ctrl_o, 8'h06);

    // R10 transmit overflow
    c0 = txovf_n;
    for (int i = 0; i < 17; i++) push(8'(i));
    idle_cyc(1);
    chk(txovf_n == c0 + 1, "R10 tx overflow", txovf_n, c0 + 1);
    chk(size_o == 16, "R10 fill capped", size_o, 16);
    wr_ctrl(8'h46);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule